// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a pulse-width modulator. A 16-bit counter advances once per prescaled tick. The tick comes from a two-stage divider set in a control word. The counter can count upward, count downward, sweep up and down, or hold its value. While the counter runs, the block raises single-cycle strobes when the count is at zero, when it is at the period value, and when it matches either of two compare values during upward counting. It also reports the current count direction. Output-pin logic further down the chip uses these strobes to set, clear or toggle waveforms.

Software sets the block through a small write-only register port with four words. The control word is at address 0, the period at address 1, compare A at address 2 and compare B at address 3. A period write can take effect at once. It can also be held in a shadow copy until the counter next reaches zero, so that a period change never splits a PWM cycle.

Top module: `tbc_timebase`

## Requirements
- R1: After reset, the count is 0 and the direction output is 1. The mode is hold (11), the period, shadow and compare values are 0, and no strobe is active.
- R2: The tick rate is the clock divided by 2^C × H. C is control bits 12:10. H is 1 when control bits 9:7 equal zero and twice their value otherwise. A control write restarts the divider, so the first tick is asserted in the D-th clock cycle after the write edge, where D is the total divide.
- R3: Mode 00 (bits 1:0) counts up from 0 to the period value inclusive and then returns to 0, giving period+1 ticks per cycle. A count at or above the period returns to 0 on the next tick. The direction output is 1.
- R4: Mode 01 counts down. From 0, or from a count above the period, it reloads the period value on the next tick. The direction output is 0.
- R5: Mode 10 counts up until the count reaches the period value, then counts down until 0, and repeats. It reverses direction on the tick at each end. The direction output is 1 while rising.
- R6: Mode 11 holds both the count and the direction, and no strobe is raised while the mode is 11.
- R7: The zero and period strobes are high for exactly the one clock cycle in which a tick is asserted, the mode is not 11, and the count equals 0 or the period value respectively.
- R8: The compare A and compare B strobes are high in a tick cycle, outside mode 11, when the count equals that compare value and the direction is up.
- R9: When control bit 3 is 0, a period write updates only the shadow copy. The active period takes the shadow value on the tick where the zero strobe fires.
- R10: When control bit 3 is 1, a period write updates the active period and the shadow copy at the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 compare A, 3 compare B |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| dir_up | output | 1 | 1 while counting up |
| evt_zero | output | 1 | Counter-at-zero strobe |
| evt_period | output | 1 | Counter-at-period strobe |
| evt_cmpa | output | 1 | Compare A match while counting up |
| evt_cmpb | output | 1 | Compare B match while counting up |

## Verification
A register write lands at the rising edge that samples it. A new mode or period first acts on the next tick after that edge. A control write restarts the divider, so with total divide D the count first moves D edges after the write edge. The strobes are combinational from registered state, so they are visible during the tick cycle itself, before the edge that moves the count. The bench advances an independent model of these rules at each rising edge, queues the expected outputs, and compares them at the following falling edge. This keeps the sampling away from the edge where the outputs change. Direct checks then measure the interval between zero strobes, the hold in mode 11, and the largest count reached around shadow and immediate period writes.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    typedef enum logic [1:0] {
        CM_UP     = 2'b00,
        CM_DOWN   = 2'b01,
        CM_UPDOWN = 2'b10,
        CM_FREEZE = 2'b11
    } cnt_mode_e;

    localparam int ADDR_W     = 2;
    localparam int DIV_FLD_W  = 3;
    localparam int MODE_LSB   = 0;
    localparam int LOAD_BIT   = 3;
    localparam int HS_LSB     = 7;
    localparam int COARSE_LSB = 10;

    localparam int A_CTRL   = 0;
    localparam int A_PERIOD = 1;
    localparam int A_CMP0   = 2;

    typedef struct packed {
        logic [DIV_FLD_W-1:0] coarse;
        logic [DIV_FLD_W-1:0] hs;
        logic                 load_now;
        cnt_mode_e            mode;
    } ctrl_t;
endpackage

// File: rtl/tbc_regs.sv
module tbc_regs
    import tbc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    input  logic                            zero_evt,
    output ctrl_t                           ctrl,
    output logic                            ctrl_wr,
    output logic [CNT_W-1:0]                prd_act,
    output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val
);
    typedef struct packed {
        ctrl_t                          ctrl;
        logic [CNT_W-1:0]               prd;
        logic [CNT_W-1:0]               shd;
        logic [NUM_CMP-1:0][CNT_W-1:0]  cmp;
    } reg_s;

    reg_s reg_d, reg_q;
    logic prd_wr;

    always_comb begin
        reg_d   = reg_q;
        ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        prd_wr  = wr_en && (wr_addr == ADDR_W'(A_PERIOD));
        if (zero_evt) begin
            reg_d.prd = reg_q.shd;
        end
        if (ctrl_wr) begin
            reg_d.ctrl.mode     = cnt_mode_e'(wr_data[MODE_LSB +: 2]);
            reg_d.ctrl.load_now = wr_data[LOAD_BIT];
            reg_d.ctrl.hs       = wr_data[HS_LSB +: DIV_FLD_W];
            reg_d.ctrl.coarse   = wr_data[COARSE_LSB +: DIV_FLD_W];
        end
        if (prd_wr) begin
            reg_d.shd = wr_data;
            if (reg_q.ctrl.load_now) begin
                reg_d.prd = wr_data;
            end
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(A_CMP0 + i))) begin
                reg_d.cmp[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q           <= '0;
            reg_q.ctrl.mode <= CM_FREEZE;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign ctrl    = reg_q.ctrl;
    assign prd_act = reg_q.prd;
    assign cmp_val = reg_q.cmp;

    // R10: an immediate write is active after the write edge
    a_r10_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_wr && reg_q.ctrl.load_now) |=> (reg_q.prd == $past(wr_data)));

    // R9: a shadow write leaves the active period alone until zero
    a_r9_shadow_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_wr && !reg_q.ctrl.load_now && !zero_evt) |=> $stable(reg_q.prd));

    // R9: the zero strobe transfers the shadow copy
    a_r9_zero_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !(prd_wr && reg_q.ctrl.load_now)) |=> (reg_q.prd == $past(reg_q.shd)));
endmodule

// File: rtl/tbc_prescaler.sv
module tbc_prescaler #(
    parameter int FLD_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [FLD_W-1:0] coarse,
    input  logic [FLD_W-1:0] hs,
    output logic             tick
);
    localparam int HS_MAX = (1 << FLD_W) - 1;
    localparam int PRE_W  = HS_MAX + $clog2(2 * HS_MAX + 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_s;

    pre_s pre_d, pre_q;
    logic [PRE_W-1:0] hs_mult;
    logic [PRE_W-1:0] div_m1;

    always_comb begin
        hs_mult = (hs == '0) ? PRE_W'(1) : PRE_W'({hs, 1'b0});
        div_m1  = (hs_mult << coarse) - PRE_W'(1);
        tick    = (pre_q.pre >= div_m1);
        pre_d   = pre_q;
        if (restart || tick) begin
            pre_d.pre = '0;
        end else begin
            pre_d.pre = pre_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R2: after a restart the first tick waits the full divide
    a_r2_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tick == (div_m1 == '0)));

    // R2: with a divide above one, ticks never come back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_m1 != '0) && !restart) |=> !tick);
endmodule

// File: rtl/tbc_counter.sv
module tbc_counter
    import tbc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  cnt_mode_e                     mode,
    input  logic [CNT_W-1:0]              prd,
    input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0]              cnt,
    output logic                          dir_up,
    output logic                          evt_zero,
    output logic                          evt_prd,
    output logic [NUM_CMP-1:0]            evt_cmp
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
    } cnt_s;

    cnt_s cnt_d, cnt_q;
    logic at_top;
    logic live;

    always_comb begin
        cnt_d  = cnt_q;
        at_top = (cnt_q.cnt >= prd);
        unique case (mode)
            CM_UP: begin
                cnt_d.dir = 1'b1;
                if (tick) begin
                    cnt_d.cnt = at_top ? '0 : cnt_q.cnt + CNT_W'(1);
                end
            end
            CM_DOWN: begin
                cnt_d.dir = 1'b0;
                if (tick) begin
                    cnt_d.cnt = ((cnt_q.cnt == '0) || (cnt_q.cnt > prd))
                                ? prd : cnt_q.cnt - CNT_W'(1);
                end
            end
            CM_UPDOWN: begin
                if (tick) begin
                    if (cnt_q.dir) begin
                        if (at_top) begin
                            cnt_d.dir = 1'b0;
                            cnt_d.cnt = (cnt_q.cnt == '0) ? '0 : cnt_q.cnt - CNT_W'(1);
                        end else begin
                            cnt_d.cnt = cnt_q.cnt + CNT_W'(1);
                        end
                    end else if (cnt_q.cnt == '0) begin
                        cnt_d.dir = 1'b1;
                        cnt_d.cnt = (prd == '0) ? '0 : CNT_W'(1);
                    end else begin
                        cnt_d.cnt = cnt_q.cnt - CNT_W'(1);
                    end
                end
            end
            default: begin
                cnt_d = cnt_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.cnt <= '0;
            cnt_q.dir <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign live     = tick && (mode != CM_FREEZE);
    assign evt_zero = live && (cnt_q.cnt == '0);
    assign evt_prd  = live && (cnt_q.cnt == prd);
    assign cnt      = cnt_q.cnt;
    assign dir_up   = cnt_q.dir;

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        assign evt_cmp[g] = live && cnt_q.dir && (cnt_q.cnt == cmp_val[g]);
    end

    // R3: below the period an up tick adds one
    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_UP && tick && cnt_q.cnt < prd) |=> (cnt_q.cnt == $past(cnt_q.cnt) + 1'b1));

    // R3: at or above the period an up tick returns to zero
    a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_UP && tick && cnt_q.cnt >= prd) |=> (cnt_q.cnt == '0));

    // R4: a down tick at zero reloads the period
    a_r4_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_DOWN && tick && cnt_q.cnt == '0) |=> (cnt_q.cnt == $past(prd)));

    // R5: rising at the top turns the direction down
    a_r5_reverse_top: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_UPDOWN && tick && cnt_q.dir && cnt_q.cnt >= prd) |=> !cnt_q.dir);

    // R6: hold mode keeps count and direction
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_FREEZE) |=> ($stable(cnt_q.cnt) && $stable(cnt_q.dir)));

    // R7: a zero strobe only appears with a prescaler tick
    a_r7_zero_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        evt_zero |-> tick);
endmodule

// File: rtl/tbc_timebase.sv
module tbc_timebase
    import tbc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              dir_up,
    output logic              evt_zero,
    output logic              evt_period,
    output logic              evt_cmpa,
    output logic              evt_cmpb
);
    localparam int NUM_CMP = 2;

    ctrl_t                          ctrl;
    logic                           ctrl_wr;
    logic                           tick;
    logic [CNT_W-1:0]               prd_act;
    logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_val;
    logic [NUM_CMP-1:0]             evt_cmp;

    tbc_regs #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .zero_evt (evt_zero),
        .ctrl     (ctrl),
        .ctrl_wr  (ctrl_wr),
        .prd_act  (prd_act),
        .cmp_val  (cmp_val)
    );

    tbc_prescaler #(.FLD_W(DIV_FLD_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .coarse  (ctrl.coarse),
        .hs      (ctrl.hs),
        .tick    (tick)
    );

    tbc_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (ctrl.mode),
        .prd      (prd_act),
        .cmp_val  (cmp_val),
        .cnt      (count),
        .dir_up   (dir_up),
        .evt_zero (evt_zero),
        .evt_prd  (evt_period),
        .evt_cmp  (evt_cmp)
    );

    assign evt_cmpa = evt_cmp[0];
    assign evt_cmpb = evt_cmp[1];
endmodule

// File: tb/tbc_timebase_tb.sv
module tbc_timebase_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] count;
    logic        dir_up, evt_zero, evt_period, evt_cmpa, evt_cmpb;

    always #5 clk = ~clk;

    tbc_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .dir_up(dir_up), .evt_zero(evt_zero), .evt_period(evt_period),
        .evt_cmpa(evt_cmpa), .evt_cmpb(evt_cmpb)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    string cur_tag = "R1";
    bit    done = 0;

    typedef struct {
        int cnt;
        bit dir, ez, ep, ea, eb;
    } exp_t;
    exp_t exq[$];

    // model of the requirements
    int m_mode, m_imm, m_coarse, m_hs, m_prd, m_shd, m_ca, m_cb, m_cnt, m_dir, m_pre;

    function automatic int m_div();
        return ((m_hs == 0) ? 1 : 2 * m_hs) << m_coarse;
    endfunction

    function automatic bit m_tick();
        return m_pre == m_div() - 1;
    endfunction

    function automatic exp_t m_expect();
        exp_t e;
        bit   act;
        act   = m_tick() && (m_mode != 3);
        e.cnt = m_cnt;
        e.dir = m_dir[0];
        e.ez  = act && (m_cnt == 0);
        e.ep  = act && (m_cnt == m_prd);
        e.ea  = act && m_dir[0] && (m_cnt == m_ca);
        e.eb  = act && m_dir[0] && (m_cnt == m_cb);
        return e;
    endfunction

    task automatic m_reset();
        m_mode = 3; m_imm = 0; m_coarse = 0; m_hs = 0;
        m_prd = 0; m_shd = 0; m_ca = 0; m_cb = 0;
        m_cnt = 0; m_dir = 1; m_pre = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            bit tk, zev;
            int nc, nd;
            tk  = m_tick();
            zev = tk && (m_mode != 3) && (m_cnt == 0);
            nc  = m_cnt;
            nd  = m_dir;
            case (m_mode)
                0: begin
                    nd = 1;
                    if (tk) nc = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
                end
                1: begin
                    nd = 0;
                    if (tk) nc = (m_cnt == 0 || m_cnt > m_prd) ? m_prd : m_cnt - 1;
                end
                2: begin
                    if (tk) begin
                        if (m_dir == 1) begin
                            if (m_cnt >= m_prd) begin
                                nd = 0;
                                nc = (m_cnt == 0) ? 0 : m_cnt - 1;
                            end else nc = m_cnt + 1;
                        end else if (m_cnt == 0) begin
                            nd = 1;
                            nc = (m_prd == 0) ? 0 : 1;
                        end else nc = m_cnt - 1;
                    end
                end
                default: ;
            endcase
            if (wr_en && wr_addr == 2'd0) m_pre = 0;
            else if (tk) m_pre = 0;
            else m_pre = m_pre + 1;
            if (zev) m_prd = m_shd;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_mode   = int'(wr_data[1:0]);
                        m_imm    = int'(wr_data[3]);
                        m_hs     = int'(wr_data[9:7]);
                        m_coarse = int'(wr_data[12:10]);
                    end
                    2'd1: begin
                        if (m_imm == 1) m_prd = int'(wr_data);
                        m_shd = int'(wr_data);
                    end
                    2'd2: m_ca = int'(wr_data);
                    default: m_cb = int'(wr_data);
                endcase
            end
            m_cnt = nc;
            m_dir = nd;
            exq.push_back(m_expect());
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (rst_n && exq.size() > 0) begin
            exp_t e;
            e = exq.pop_front();
            chk({cur_tag, " count"}, int'(count), e.cnt);
            chk({cur_tag, " dir"}, int'(dir_up), int'(e.dir));
            chk("R7 zero strobe", int'(evt_zero), int'(e.ez));
            chk("R7 period strobe", int'(evt_period), int'(e.ep));
            chk("R8 cmpA strobe", int'(evt_cmpa), int'(e.ea));
            chk("R8 cmpB strobe", int'(evt_cmpb), int'(e.eb));
        end
    end

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_zero();
        int guard = 0;
        while (!evt_zero && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic measure_r2(input int exp);
        int n = 0;
        wait_zero();
        do begin
            @(negedge clk);
            n++;
        end while (!evt_zero && n < 5000);
        chk("R2 zero-to-zero clocks", n, exp);
    endtask

    task automatic max_to_zero(output int mx);
        int n = 0;
        mx = 0;
        do begin
            @(negedge clk);
            n++;
            if (int'(count) > mx) mx = int'(count);
        end while (!evt_zero && n < 5000);
    endtask

    initial begin
        int c0, d0, ev, mx;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset count", int'(count), 0);
        chk("R1 reset dir", int'(dir_up), 1);
        chk("R1 reset strobes", int'(evt_zero) + int'(evt_period) + int'(evt_cmpa) + int'(evt_cmpb), 0);
        rst_n = 1'b1;
        idle(5);
        chk("R1 hold after reset", int'(count), 0);

        cur_tag = "R3";
        wr(2, 2);
        wr(3, 5);
        wr(0, 16'h000B);
        wr(1, 6);
        wr(0, 16'h0008);
        idle(30);

        cur_tag = "R2";
        wr(0, 16'h0488);
        measure_r2(28);
        wr(0, 16'h0988);
        measure_r2(168);

        cur_tag = "R4";
        wr(0, 16'h0009);
        idle(30);

        cur_tag = "R5";
        wr(0, 16'h000A);
        idle(40);
        wr(2, 6);
        wr(3, 0);
        idle(30);
        wr(0, 16'h008A);
        idle(60);

        cur_tag = "R6";
        wr(0, 16'h000B);
        idle(2);
        c0 = int'(count);
        d0 = int'(dir_up);
        ev = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ev += int'(evt_zero) + int'(evt_period) + int'(evt_cmpa) + int'(evt_cmpb);
        end
        chk("R6 held count", int'(count), c0);
        chk("R6 held dir", int'(dir_up), d0);
        chk("R6 no strobes", ev, 0);

        cur_tag = "R9";
        wr(2, 2);
        wr(3, 5);
        wr(0, 16'h0000);
        wait_zero();
        wr(1, 10);
        max_to_zero(mx);
        chk("R9 old period kept until zero", mx, 6);
        max_to_zero(mx);
        chk("R9 shadow period after zero", mx, 10);

        cur_tag = "R10";
        wr(0, 16'h0008);
        idle(5);
        wr(1, 2);
        @(negedge clk);
        mx = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
        end
        chk("R10 immediate period", mx, 2);
        idle(5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule